// File: doc/BRIEF.md
# Load Register Lock Scoreboard

This block keeps one lock flag for every architectural register of an in-order pipeline whose data cache does not block on misses. When decode issues a load, the block locks the load's destination register and emits a memory request tagged with that register number. Loads may return in any order through a response queue. Each response carries the register tag, so the returning data can be routed to the correct register.

At decode, any instruction that reads or writes a locked register is held by a stall signal. When a response arrives, the block writes its data into the register file through a write port reserved for responses, pops the response, and unlocks the register on the next clock edge. This port never competes with the main pipeline's write-back.

Each register's lock is a two-state machine:

- States: `LK_FREE` (not waiting on a load) and `LK_HELD` (waiting on an outstanding load).
- Transitions:
  - `ISSUE` moves `LK_FREE` to `LK_HELD`. It is taken when a load naming this register leaves decode.
  - `RETURN` moves `LK_HELD` to `LK_FREE`. It is taken when a response names this register.
  - `COLLIDE`: when `ISSUE` and `RETURN` occur in the same cycle, the register ends in `LK_HELD`.

Register 0 has no state machine and is permanently `LK_FREE`.

Top module: `ldlock_scoreboard`

## Requirements
- R1: After reset every register is unlocked, so no decoded instruction stalls until a load has been issued.
- R2: While `dec_valid` is 1, `dec_stall` is 1 in the same cycle exactly when the lock of `dec_src_a`, `dec_src_b` or `dec_dst` is set. While `dec_valid` is 0, `dec_stall` is 0.
- R3: A load that is not stalled (`dec_valid`=1, `dec_is_load`=1, `dec_stall`=0) sets the lock of `dec_dst` at the next clock edge.
- R4: In the cycle a load issues, `req_valid` is 1 and the 5-bit `req_tag` equals `dec_dst`. `req_valid` is 0 in any cycle with no issuing load, including a stalled one.
- R5: While `rsp_valid` is 1, `rf_we` is 1 in the same cycle, with `rf_waddr` equal to `rsp_tag` and `rf_wdata` equal to `rsp_data`. The lock of `rsp_tag` is cleared at the next clock edge.
- R6: Responses may return in any order. A response clears only the register it names, and other registers keep their locks.
- R7: If a load issues to a register in the same cycle as a response naming that register, the register is locked after the edge.
- R8: Register 0 is never locked. A load to register 0 sends its request but leaves no lock, and operands of register 0 never stall.
- R9: `rsp_pop` is 1 only in a cycle in which `rf_we` is 1 for that response. With `rsp_valid` at 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_src_a | input | 5 | First source register |
| dec_src_b | input | 5 | Second source register |
| dec_dst | input | 5 | Destination register |
| dec_is_load | input | 1 | The decoded instruction is a load |
| dec_stall | output | 1 | Hold the decoded instruction |
| req_valid | output | 1 | Load request pushed to the memory queue |
| req_tag | output | 5 | Destination register carried by the request |
| rsp_valid | input | 1 | Response queue has an entry |
| rsp_tag | input | 5 | Register named by the response |
| rsp_data | input | 32 | Returned load data |
| rsp_pop | output | 1 | Remove the head response |
| rf_we | output | 1 | Write enable of the response write port |
| rf_waddr | output | 5 | Register written by the response port |
| rf_wdata | output | 32 | Data written by the response port |

## Verification
Some behaviours are checked by the assertions on every cycle:

- a stalled instruction never produces a request;
- an issued load makes the next decode that reads its register stall;
- a set or a collision always leaves the lock held, and a lone clear always frees it;
- a pop always coincides with a write of the response's register;
- operands of register 0 never stall.

The bench's directed scenarios are needed for the rest. They show that responses return out of order while other locks survive. They show the set-over-clear collision as seen from later decode stalls. They also cover the absence of any lock after a load to register 0, and the exact data and address presented on the write port.

// File: rtl/ldlock_pkg.sv
package ldlock_pkg;
    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/ldlock_cell.sv
module ldlock_cell
    import ldlock_pkg::*;
#(
    parameter bit TIED_FREE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic lock_o
);
    generate
        if (TIED_FREE) begin : g_tied
            assign lock_o = 1'b0;
        end else begin : g_fsm
            lock_state_e state_q, state_d;

            always_ff @(posedge clk) begin
                if (!rst_n) state_q <= LK_FREE;
                else        state_q <= state_d;
            end

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    LK_FREE: if (set_i) state_d = LK_HELD;        // ISSUE / COLLIDE
                    LK_HELD: if (clr_i && !set_i) state_d = LK_FREE; // RETURN
                    default: state_d = LK_FREE;
                endcase
            end

            assign lock_o = (state_q == LK_HELD);

            AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                set_i |=> lock_o);                          // R7
            AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !set_i) |=> !lock_o);             // R5
        end
    endgenerate
endmodule

// File: rtl/ldlock_hazard.sv
module ldlock_hazard #(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic [NREG-1:0] lock_i,
    input  logic            valid_i,
    input  logic [RW-1:0]   src_a_i,
    input  logic [RW-1:0]   src_b_i,
    input  logic [RW-1:0]   dst_i,
    output logic            stall_o
);
    always_comb begin
        stall_o = valid_i && (lock_i[src_a_i] || lock_i[src_b_i] || lock_i[dst_i]);
    end

    always_comb begin
        if (valid_i && src_a_i == '0 && src_b_i == '0 && dst_i == '0)
            AST_R0_NO_STALL: assert (!stall_o);             // R8
    end
endmodule

// File: rtl/ldlock_scoreboard.sv
module ldlock_scoreboard #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [RW-1:0] dec_src_a,
    input  logic [RW-1:0] dec_src_b,
    input  logic [RW-1:0] dec_dst,
    input  logic          dec_is_load,
    output logic          dec_stall,
    output logic          req_valid,
    output logic [RW-1:0] req_tag,
    input  logic          rsp_valid,
    input  logic [RW-1:0] rsp_tag,
    input  logic [DW-1:0] rsp_data,
    output logic          rsp_pop,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);
    logic [NREG-1:0] lock_vec;
    logic            load_issue;

    ldlock_hazard #(.NREG(NREG)) u_hazard (
        .lock_i  (lock_vec),
        .valid_i (dec_valid),
        .src_a_i (dec_src_a),
        .src_b_i (dec_src_b),
        .dst_i   (dec_dst),
        .stall_o (dec_stall)
    );

    assign load_issue = dec_valid && dec_is_load && !dec_stall;

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            ldlock_cell #(.TIED_FREE(r == 0)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (load_issue && dec_dst == RW'(r)),
                .clr_i  (rsp_valid && rsp_tag == RW'(r)),
                .lock_o (lock_vec[r])
            );
        end
    endgenerate

    // Request toward the memory queue: destination register is the tag.
    always_comb begin
        req_valid = load_issue;
        req_tag   = dec_dst;
    end

    // Dedicated response write port: always free, so every response is
    // written and popped in the cycle it is presented.
    always_comb begin
        rf_we    = rsp_valid;
        rf_waddr = rsp_tag;
        rf_wdata = rsp_data;
        rsp_pop  = rsp_valid && rf_we;
    end

    AST_NO_REQ_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |-> !req_valid);                                  // R4
    AST_LOAD_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tag != '0) ##1 (dec_valid && dec_src_a == $past(req_tag))
        |-> dec_stall);                                             // R3
    AST_POP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pop |-> (rf_we && rf_waddr == rsp_tag));                // R9
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_stall);                                 // R2
endmodule

// File: tb/ldlock_scoreboard_tb.sv
module ldlock_scoreboard_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid, dec_is_load;
    logic [4:0]  dec_src_a, dec_src_b, dec_dst;
    logic        dec_stall, req_valid;
    logic [4:0]  req_tag;
    logic        rsp_valid;
    logic [4:0]  rsp_tag;
    logic [31:0] rsp_data;
    logic        rsp_pop, rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ldlock_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .dec_dst(dec_dst), .dec_is_load(dec_is_load), .dec_stall(dec_stall),
        .req_valid(req_valid), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .rsp_pop(rsp_pop), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        dec_valid = 0; dec_is_load = 0; dec_src_a = 0; dec_src_b = 0; dec_dst = 0;
        rsp_valid = 0; rsp_tag = 0; rsp_data = 0;
    endtask

    // Move to the next negedge (one posedge passes), clear inputs.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic decode(input logic [4:0] a, input logic [4:0] b,
                          input logic [4:0] d, input logic ld);
        dec_valid = 1; dec_src_a = a; dec_src_b = b; dec_dst = d; dec_is_load = ld;
        #1;
    endtask

    task automatic respond(input logic [4:0] t, input logic [31:0] data);
        rsp_valid = 1; rsp_tag = t; rsp_data = data;
        #1;
    endtask

    task automatic t_reset();
        for (int r = 0; r < 32; r += 7) begin
            decode(5'(r), 5'(r), 5'(r), 1'b0);
            check("R1 no stall after reset", dec_stall, 0);
        end
        idle(); #1;
        check("R9 pop idle", rsp_pop, 0);
        check("R9 we idle", rf_we, 0);
        step();
    endtask

    task automatic t_issue_and_stall();
        decode(5'd1, 5'd2, 5'd5, 1'b1);
        check("R4 req_valid", req_valid, 1);
        check("R4 req_tag", req_tag, 5);
        check("R3 issuing load not stalled", dec_stall, 0);
        step();
        decode(5'd5, 5'd0, 5'd6, 1'b0);
        check("R2 src_a locked", dec_stall, 1);
        decode(5'd0, 5'd5, 5'd6, 1'b0);
        check("R2 src_b locked", dec_stall, 1);
        decode(5'd1, 5'd2, 5'd5, 1'b1);
        check("R2 dst locked", dec_stall, 1);
        check("R4 no req when stalled", req_valid, 0);
        decode(5'd1, 5'd2, 5'd6, 1'b0);
        check("R2 unrelated free", dec_stall, 0);
        dec_valid = 0; dec_src_a = 5; #1;
        check("R2 no stall without valid", dec_stall, 0);
        step();
    endtask

    task automatic t_response();
        respond(5'd5, 32'hCAFE_0005);
        check("R5 rf_we", rf_we, 1);
        check("R5 rf_waddr", rf_waddr, 5);
        check("R5 rf_wdata", rf_wdata, 32'hCAFE_0005);
        check("R9 pop with write", rsp_pop, 1);
        step();
        decode(5'd5, 5'd0, 5'd0, 1'b0);
        check("R5 cleared after response", dec_stall, 0);
        step();
    endtask

    task automatic t_out_of_order();
        decode(5'd0, 5'd0, 5'd7, 1'b1); step();
        decode(5'd0, 5'd0, 5'd9, 1'b1); step();
        respond(5'd9, 32'h99); step();
        decode(5'd9, 5'd0, 5'd0, 1'b0);
        check("R6 r9 freed", dec_stall, 0);
        decode(5'd7, 5'd0, 5'd0, 1'b0);
        check("R6 r7 still locked", dec_stall, 1);
        step();
        respond(5'd7, 32'h77); step();
        decode(5'd7, 5'd0, 5'd0, 1'b0);
        check("R6 r7 freed", dec_stall, 0);
        step();
    endtask

    task automatic t_collision();
        decode(5'd0, 5'd0, 5'd3, 1'b1);
        respond(5'd3, 32'h33);
        check("R7 issue during response", req_valid, 1);
        step();
        decode(5'd3, 5'd0, 5'd0, 1'b0);
        check("R7 set wins over clear", dec_stall, 1);
        step();
        respond(5'd3, 32'h34); step();
        decode(5'd3, 5'd0, 5'd0, 1'b0);
        check("R7 later clear frees", dec_stall, 0);
        step();
    endtask

    task automatic t_reg_zero();
        decode(5'd0, 5'd0, 5'd0, 1'b1);
        check("R8 request for r0", req_valid, 1);
        check("R8 tag r0", req_tag, 0);
        step();
        decode(5'd0, 5'd0, 5'd0, 1'b1);
        check("R8 r0 never locked", dec_stall, 0);
        step();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_issue_and_stall();
        t_response();
        t_out_of_order();
        t_collision();
        t_reg_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule